// File: doc/BRIEF.md
# Pad Pull-Resistor Control Latch

This block stores the pull-resistor setting for a bank of pads and drives a pull-up enable and a pull-down enable for each one. Software writes one shared 2-bit pull code over a simple register port. It then raises bits in two clock-enable registers. A pad copies the shared code only at the moment its own clock-enable bit goes from 0 to 1. Every other pad keeps the setting it already has.

The shared code has to be steady for a minimum number of clock cycles before a pad's enable bit rises (setup). It also has to stay steady for a minimum number of cycles after that rise (hold). The block measures both windows with saturating counters. A breach of either window sets a sticky status flag, and software clears that flag by writing a 1 to it. The capture still happens when a window is breached, so the flags only report the fault.

Top module: `pad_pull_latch`

## Requirements
- R1: After reset, every pad has pull disabled (both enables 0). The control, clock-enable and status registers all read 0.
- R2: Registers:
  - 0x94 is the control register. The code sits in bits 1:0 and the other bits read 0.
  - 0x98 is the low clock-enable register. Bit n selects pad n, for n from 0 to 31.
  - 0x9C is the high clock-enable register. Bit n-32 selects pad n, and bits at or above NUM_PADS-32 read 0.
  - 0xA0 is the status register. Bit 0 is the setup flag and bit 1 is the hold flag.
  - Any other address reads 0. Reads are combinational from the address.
- R3: When a write makes a pad's clock-enable bit go from 0 to 1, that pad takes the current control code. The new state shows on the outputs after the same clock edge that accepts the write.
- R4: A pad whose clock-enable bit does not rise keeps its state. This holds when its bit is already 1 and gets rewritten, and when the control code changes while its bit is 1.
- R5: Pad code decoding:
  - 1 asserts only the pull-down enable.
  - 2 asserts only the pull-up enable.
  - 0 asserts neither enable.
  - 3 is reserved and also asserts neither enable.
- R6: Let k be the number of clock edges between the edge that changed the control code and the edge that accepts a clock-enable rise. If k is less than SETUP_CYC, status bit 0 is set; otherwise it is not. Writing the value the control register already holds does not count as a change.
- R7: Let d be the number of clock edges between the most recent clock-enable rise and a change of the control code. Status bit 1 is set when d is less than HOLD_CYC and a pad that rose in that window still has its enable bit high. It is not set otherwise.
- R8: Each status flag stays set until a write to 0xA0 with a 1 in that bit position. A 0 in that position leaves the flag unchanged.
- R9: After reset both window counters start out as expired, so a rise with no earlier control change flags nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| pull_up_en | output | NUM_PADS | Pull-up enable per pad |
| pull_dn_en | output | NUM_PADS | Pull-down enable per pad |

## Verification
The bench builds the block with 40 pads, a setup window of 6 cycles and a hold window of 5 cycles. With 40 pads the high clock-enable register is only partly used, so its unused bits can be checked. The short windows make it cheap to sweep every setup distance from 1 to 7 edges and every hold distance from 1 to 6 edges. Each sweep covers both sides of the limit. Every pad is configured one at a time, with all four codes in rotation, and the bench keeps its own shadow of the enable registers to predict which pads must capture.

// File: rtl/pull_pkg.sv
package pull_pkg;

  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_code_e;

  function automatic logic code_is_up(input logic [1:0] code);
    return code == PULL_UP;
  endfunction

  function automatic logic code_is_down(input logic [1:0] code);
    return code == PULL_DOWN;
  endfunction

  // Saturating step of a cycle counter toward lim.
  function automatic int unsigned step_sat(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // A window is still open while fewer than lim edges have passed.
  function automatic logic window_open(input int unsigned v, input int unsigned lim);
    return v < lim;
  endfunction

endpackage

// File: rtl/pull_regs.sv
module pull_regs #(
  parameter int          NUM_PADS = 54,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  CTL_OFS  = 8'h94,
  parameter logic [7:0]  LO_OFS   = 8'h98,
  parameter logic [7:0]  HI_OFS   = 8'h9C,
  parameter logic [7:0]  ST_OFS   = 8'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  input  logic [1:0]          status_i,
  output logic [1:0]          ctl_q,
  output logic [NUM_PADS-1:0] clken_q,
  output logic [NUM_PADS-1:0] rise_o,
  output logic                ctl_change_o,
  output logic [1:0]          clr_o,
  output logic [31:0]         rd_data
);
  localparam int HI_W = NUM_PADS - 32;

  logic                wr_ctl, wr_lo, wr_hi, wr_st;
  logic [NUM_PADS-1:0] clken_next;

  assign wr_ctl = wr_en && (addr == ADDR_W'(CTL_OFS));
  assign wr_lo  = wr_en && (addr == ADDR_W'(LO_OFS));
  assign wr_hi  = wr_en && (addr == ADDR_W'(HI_OFS));
  assign wr_st  = wr_en && (addr == ADDR_W'(ST_OFS));

  always_comb begin
    clken_next = clken_q;
    if (wr_lo) clken_next[31:0] = wdata;
    if (wr_hi) clken_next[NUM_PADS-1:32] = wdata[HI_W-1:0];
  end

  assign rise_o       = clken_next & ~clken_q;
  assign ctl_change_o = wr_ctl && (wdata[1:0] != ctl_q);
  assign clr_o        = wr_st ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= 2'b00;
      clken_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wdata[1:0];
      clken_q <= clken_next;
    end
  end

  always_comb begin
    rd_data = 32'd0;
    if (addr == ADDR_W'(CTL_OFS))     rd_data = {30'd0, ctl_q};
    else if (addr == ADDR_W'(LO_OFS)) rd_data = clken_q[31:0];
    else if (addr == ADDR_W'(HI_OFS)) rd_data = {{(32-HI_W){1'b0}}, clken_q[NUM_PADS-1:32]};
    else if (addr == ADDR_W'(ST_OFS)) rd_data = {30'd0, status_i};
  end

endmodule

// File: rtl/pull_timing.sv
module pull_timing #(
  parameter int NUM_PADS  = 54,
  parameter int SETUP_CYC = 150,
  parameter int HOLD_CYC  = 150
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_change,
  input  logic [NUM_PADS-1:0] rise,
  input  logic [NUM_PADS-1:0] clken_q,
  input  logic [1:0]          clr,
  output logic                setup_hit,
  output logic                hold_hit,
  output logic                setup_flag,
  output logic                hold_flag
);
  import pull_pkg::*;

  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [SW-1:0]       setup_cnt;
  logic [HW-1:0]       hold_cnt;
  logic [NUM_PADS-1:0] recent_q;
  logic                any_rise, setup_open, hold_open;

  assign any_rise   = |rise;
  assign setup_open = window_open(32'(setup_cnt), SETUP_CYC);
  assign hold_open  = window_open(32'(hold_cnt), HOLD_CYC);

  assign setup_hit = any_rise && setup_open;
  assign hold_hit  = ctl_change && hold_open && |(recent_q & clken_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_cnt  <= SW'(SETUP_CYC);
      hold_cnt   <= HW'(HOLD_CYC);
      recent_q   <= '0;
      setup_flag <= 1'b0;
      hold_flag  <= 1'b0;
    end else begin
      if (ctl_change) setup_cnt <= SW'(1);
      else            setup_cnt <= SW'(step_sat(32'(setup_cnt), SETUP_CYC));

      if (any_rise) begin
        hold_cnt <= HW'(1);
        recent_q <= (hold_open ? recent_q : '0) | rise;
      end else begin
        hold_cnt <= HW'(step_sat(32'(hold_cnt), HOLD_CYC));
      end

      setup_flag <= (setup_flag & ~clr[0]) | setup_hit;
      hold_flag  <= (hold_flag  & ~clr[1]) | hold_hit;
    end
  end

endmodule

// File: rtl/pull_pad_bank.sv
module pull_pad_bank #(
  parameter int NUM_PADS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] rise,
  input  logic [1:0]          ctl,
  output logic [NUM_PADS-1:0] pull_up_en,
  output logic [NUM_PADS-1:0] pull_dn_en
);
  import pull_pkg::*;

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_pad
    logic [1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= PULL_OFF;
      else if (rise[n]) code_q <= ctl;
    end
    assign pull_up_en[n] = code_is_up(code_q);
    assign pull_dn_en[n] = code_is_down(code_q);
  end

endmodule

// File: rtl/pad_pull_latch.sv
module pad_pull_latch #(
  parameter int          NUM_PADS  = 54,
  parameter int          SETUP_CYC = 150,
  parameter int          HOLD_CYC  = 150,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  CTL_OFS   = 8'h94,
  parameter logic [7:0]  LO_OFS    = 8'h98,
  parameter logic [7:0]  HI_OFS    = 8'h9C,
  parameter logic [7:0]  ST_OFS    = 8'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rd_data,
  output logic [NUM_PADS-1:0] pull_up_en,
  output logic [NUM_PADS-1:0] pull_dn_en
);
  // Named internal events, also observed by the bound checker.
  logic [1:0]          ctl_q;
  logic [NUM_PADS-1:0] clken_q;
  logic [NUM_PADS-1:0] rise;
  logic                ctl_change;
  logic [1:0]          clr;
  logic                setup_hit, hold_hit;
  logic                setup_flag, hold_flag;

  pull_regs #(
    .NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W),
    .CTL_OFS(CTL_OFS), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .ST_OFS(ST_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .status_i({hold_flag, setup_flag}),
    .ctl_q(ctl_q), .clken_q(clken_q), .rise_o(rise),
    .ctl_change_o(ctl_change), .clr_o(clr), .rd_data(rd_data)
  );

  pull_timing #(
    .NUM_PADS(NUM_PADS), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .ctl_change(ctl_change), .rise(rise),
    .clken_q(clken_q), .clr(clr),
    .setup_hit(setup_hit), .hold_hit(hold_hit),
    .setup_flag(setup_flag), .hold_flag(hold_flag)
  );

  pull_pad_bank #(
    .NUM_PADS(NUM_PADS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .rise(rise), .ctl(ctl_q),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
  );

endmodule

// File: rtl/pad_pull_latch_chk.sv
module pad_pull_latch_chk #(
  parameter int NUM_PADS = 54
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          ctl_q,
  input logic [NUM_PADS-1:0] rise,
  input logic                ctl_change,
  input logic [1:0]          clr,
  input logic                setup_flag,
  input logic                hold_flag,
  input logic [NUM_PADS-1:0] pull_up_en,
  input logic [NUM_PADS-1:0] pull_dn_en
);
  localparam logic [NUM_PADS-1:0] NONE = '0;

  // R4
  keep_unrisen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((((pull_up_en ^ $past(pull_up_en)) | (pull_dn_en ^ $past(pull_dn_en)))
              & ~$past(rise)) == NONE));

  // R3
  capture_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != NONE) |=> ((pull_up_en & $past(rise)) ==
                        (($past(ctl_q) == 2'd2) ? $past(rise) : NONE)));

  // R3
  capture_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != NONE) |=> ((pull_dn_en & $past(rise)) ==
                        (($past(ctl_q) == 2'd1) ? $past(rise) : NONE)));

  // R6
  setup_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_flag) |-> $past(rise != NONE));

  // R7
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_flag) |-> $past(ctl_change));

  // R8
  setup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(setup_flag) |-> $past(clr[0]));

  // R8
  hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_flag) |-> $past(clr[1]));

endmodule

bind pad_pull_latch pad_pull_latch_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .rise(rise), .ctl_change(ctl_change),
  .clr(clr), .setup_flag(setup_flag), .hold_flag(hold_flag),
  .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
);

// File: tb/pad_pull_latch_test.sv
module pad_pull_latch_test;
  localparam int NP = 40;
  localparam int SU = 6;
  localparam int HO = 5;
  localparam logic [7:0] A_CTL = 8'h94, A_LO = 8'h98, A_HI = 8'h9C, A_ST = 8'hA0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    addr = 8'h00;
  logic [31:0]   wdata = 32'd0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pull_up_en, pull_dn_en;

  always #10 clk = ~clk;

  pad_pull_latch #(.NUM_PADS(NP), .SETUP_CYC(SU), .HOLD_CYC(HO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
  );

  int total = 0;
  int bad = 0;
  logic [1:0]  model [NP];
  logic [1:0]  cur_ctl = 2'd0;
  logic [31:0] lo_sh = 32'd0;
  logic [31:0] hi_sh = 32'd0;
  logic [31:0] v;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_vec(input logic [1:0] want);
    logic [NP-1:0] r = '0;
    for (int i = 0; i < NP; i++) r[i] = (model[i] == want);
    return r;
  endfunction

  task automatic chk_pads(input string tag);
    chk({tag, " up"}, 64'(pull_up_en), 64'(exp_vec(2'd2)));
    chk({tag, " dn"}, 64'(pull_dn_en), 64'(exp_vec(2'd1)));
  endtask

  // Called at a negedge; the write is taken at the next posedge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == A_CTL) cur_ctl = d[1:0];
    if (a == A_LO) begin
      for (int i = 0; i < 32; i++) if (d[i] && !lo_sh[i]) model[i] = cur_ctl;
      lo_sh = d;
    end
    if (a == A_HI) begin
      for (int i = 0; i < NP - 32; i++) if (d[i] && !hi_sh[i]) model[32 + i] = cur_ctl;
      hi_sh = d & ((32'd1 << (NP - 32)) - 1);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    addr = a; wr_en = 1'b0;
    #1 r = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < NP; i++) model[i] = 2'd0;
    cur_ctl = 2'd0; lo_sh = 32'd0; hi_sh = 32'd0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1: reset state
    chk_pads("R1 reset pads");
    rd(A_CTL, v); chk("R1 ctl", 64'(v), 0);
    rd(A_LO, v);  chk("R1 lo", 64'(v), 0);
    rd(A_HI, v);  chk("R1 hi", 64'(v), 0);
    rd(A_ST, v);  chk("R1 status", 64'(v), 0);

    // R2: register map and read-back
    wr(A_CTL, 32'd3);          rd(A_CTL, v); chk("R2 ctl=3", 64'(v), 3);
    wr(A_CTL, 32'hFFFF_FFF2);  rd(A_CTL, v); chk("R2 ctl upper bits", 64'(v), 2);
    wr(A_CTL, 32'd0);
    wr(A_LO, 32'hA5A5_5A5A);   rd(A_LO, v);  chk("R2 lo", 64'(v), 64'hA5A5_5A5A);
    wr(A_HI, 32'hFFFF_FFFF);   rd(A_HI, v);  chk("R2 hi width", 64'(v), 64'hFF);
    rd(8'h90, v); chk("R2 unmapped", 64'(v), 0);
    rd(A_ST, v);  chk("R6 early rise after ctl change", 64'(v), 1);
    wr(A_ST, 32'd1); rd(A_ST, v); chk("R8 clear setup", 64'(v), 0);
    wr(A_LO, 32'd0); wr(A_HI, 32'd0);
    chk_pads("R3 capture of code 0");

    // R3 R5: every pad, codes in rotation, proper sequence
    for (int p = 0; p < NP; p++) begin
      wr(A_CTL, 32'(p % 4));
      idle(SU);
      if (p < 32) wr(A_LO, 32'd1 << p);
      else        wr(A_HI, 32'd1 << (p - 32));
      chk_pads($sformatf("R3 R5 pad %0d code %0d", p, p % 4));
      idle(HO);
      wr(A_CTL, 32'd0);
      if (p < 32) wr(A_LO, 32'd0); else wr(A_HI, 32'd0);
    end
    rd(A_ST, v); chk("R6 R7 clean sequence no flags", 64'(v), 0);

    // R6: setup distance sweep
    for (int k = 1; k <= SU + 1; k++) begin
      wr(A_CTL, (k % 2 == 1) ? 32'd1 : 32'd2);
      idle(k - 1);
      wr(A_LO, 32'd1);
      rd(A_ST, v);
      chk($sformatf("R6 setup k=%0d", k), 64'(v), (k < SU) ? 1 : 0);
      chk_pads("R3 capture despite setup flag");
      idle(HO);
      wr(A_LO, 32'd0);
      wr(A_ST, 32'd3);
    end
    // R6: rewriting the same control value is not a change
    wr(A_CTL, 32'(cur_ctl));
    wr(A_LO, 32'd1);
    rd(A_ST, v); chk("R6 same-value write", 64'(v), 0);
    idle(HO); wr(A_LO, 32'd0);

    // R7: hold distance sweep on pad 33
    for (int d = 1; d <= HO + 1; d++) begin
      wr(A_CTL, 32'd1);
      idle(SU);
      wr(A_HI, 32'd2);
      idle(d - 1);
      wr(A_CTL, 32'd2);
      rd(A_ST, v);
      chk($sformatf("R7 hold d=%0d", d), 64'(v), (d < HO) ? 2 : 0);
      chk_pads("R4 ctl change with bit high");
      idle(SU);
      wr(A_HI, 32'd0);
      wr(A_ST, 32'd3);
    end
    // R7: bit dropped before the change
    wr(A_CTL, 32'd1); idle(SU);
    wr(A_HI, 32'd2); wr(A_HI, 32'd0); wr(A_CTL, 32'd2);
    rd(A_ST, v); chk("R7 bit low no hold flag", 64'(v), 0);

    // R4: only rising bits capture
    wr(A_CTL, 32'd1); idle(SU);
    wr(A_LO, 32'd1 << 5); idle(HO);
    wr(A_CTL, 32'd2); idle(SU);
    wr(A_LO, 32'd1 << 5);
    chk_pads("R4 rewrite of high bit");
    wr(A_LO, (32'd1 << 5) | (32'd1 << 6));
    chk_pads("R4 only new bit captures");
    wr(A_HI, 32'hFF);
    chk_pads("R3 multi-pad high capture");
    idle(HO);
    wr(A_LO, 32'd0); wr(A_HI, 32'd0);
    rd(A_ST, v); chk("R4 no flags", 64'(v), 0);

    // R8: sticky flags and per-bit clear
    idle(SU);
    wr(A_CTL, 32'd1);
    wr(A_LO, 32'd1);
    wr(A_CTL, 32'd2);
    rd(A_ST, v); chk("R8 both flags", 64'(v), 3);
    wr(A_ST, 32'd1); rd(A_ST, v); chk("R8 clear bit0 only", 64'(v), 2);
    idle(4);         rd(A_ST, v); chk("R8 sticky", 64'(v), 2);
    wr(A_ST, 32'd0); rd(A_ST, v); chk("R8 zero write no effect", 64'(v), 2);
    wr(A_ST, 32'd2); rd(A_ST, v); chk("R8 clear bit1", 64'(v), 0);

    // R1 R9: reset mid-run, then an immediate rise
    do_reset();
    chk_pads("R1 pads after reset");
    rd(A_LO, v); chk("R1 lo after reset", 64'(v), 0);
    wr(A_LO, 32'd1);
    rd(A_ST, v); chk("R9 no flag after reset", 64'(v), 0);
    chk_pads("R9 capture after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule